// File: doc/BRIEF.md
# Exception State Registers

This block keeps the exception state of a simple processor core: a status word that carries the interrupt enables and the privilege bits, a cause word that records what went wrong and which interrupt lines are live, and an exception program counter. Each cycle the pipeline presents any synchronous exception requests as a one-hot-per-code vector, together with the PC of the instruction concerned and a flag saying whether that instruction sits in a branch delay slot. Six hardware interrupt lines are sampled into the pending field every cycle.

When a request is accepted, the block raises `trap` with the chosen code in the same cycle. On the next clock edge it sets the exception-level bit, latches the code and the branch-delay flag, and saves the restart PC. A return strobe hands the saved PC back as the next fetch address and clears the exception level. Software reads and writes the three words through a small select/write port.

Top module: `exc_state_regs`

## Requirements
- R1: Status word layout: mask in bits 15:8, user mode in bit 4, exception level in bit 1, interrupt enable in bit 0. These fields are writable with select 0, and every other bit reads 0. After reset, status, cause and EPC all read 0. Select 1 reads cause, select 2 reads EPC, and select 3 reads 0.
- R2: Cause word layout: branch-delay flag in bit 31, pending interrupts in bits 15:8, and exception code in bits 6:2. Writes with select 1 leave the whole word unchanged.
- R3: Interrupt line k appears in cause bit 10+k one clock after it is driven. Bits 9:8 always read 0.
- R4: An interrupt is taken, with code 0, when interrupt enable is 1, exception level is 0, and some pending bit k has mask bit (status bit 10+k) set. Otherwise no interrupt is taken.
- R5: Request bit k (1..15) raises `trap` with code k in the same cycle, whatever the enable and level bits are. Request bit 0 has no effect.
- R6: When several requests are active at once, the lowest-numbered synchronous code wins, and any synchronous request wins over an interrupt.
- R7: On the edge after `trap`, the exception level becomes 1 and the code is recorded. EPC gets the faulting PC, or that PC minus 4 when the delay-slot flag is set. The branch-delay bit copies the delay-slot flag.
- R8: While the return strobe is high, `resume_valid` is 1 and `resume_pc` equals EPC. On the next edge the exception level clears.
- R9: In one cycle a trap takes precedence over a return, and a return takes precedence over a register write. A write with select 2 loads EPC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req | input | 16 | Synchronous exception requests, bit k = code k |
| irq | input | 6 | Hardware interrupt lines |
| fault_pc | input | 32 | PC of the instruction being excepted |
| in_delay | input | 1 | That instruction is in a branch delay slot |
| eret | input | 1 | Return-from-exception strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 cause, 2 EPC |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| trap | output | 1 | Exception taken this cycle |
| trap_code | output | 5 | Code of the exception taken |
| resume_valid | output | 1 | Next fetch comes from EPC |
| resume_pc | output | 32 | Saved restart PC |
| status_q | output | 32 | Status word |
| cause_q | output | 32 | Cause word |
| epc_q | output | 32 | Exception PC |

## Verification
The hardest case to reach is an interrupt decision for a particular mask and line pattern. Reaching it needs three things in order: a status write that clears the exception level, a cycle for the lines to land in the pending field, and a clean gap after each taken interrupt so the next write is not lost behind the trap that follows. The bench runs this sequence for all 64 masks against all 64 line patterns. It also drives every pair of synchronous codes together, to cover the priority encoder, and sets up the same-cycle collisions of trap, return and write.

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int IRQ_N  = 6,
  parameter int CODE_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_N-1:0] sync_req,
  input  logic [IRQ_N-1:0]  irq,
  input  logic [31:0]       fault_pc,
  input  logic              in_delay,
  input  logic              eret,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              trap,
  output logic [4:0]        trap_code,
  output logic              resume_valid,
  output logic [31:0]       resume_pc,
  output logic [31:0]       status_q,
  output logic [31:0]       cause_q,
  output logic [31:0]       epc_q
);
  localparam int PAD = 8 - IRQ_N;

  logic [7:0]       mask_q;
  logic             um_q, el_q, ie_q, bd_q;
  logic [4:0]       code_q;
  logic [IRQ_N-1:0] pend_q;
  logic [31:0]      epc_r;
  logic             sync_any, irq_hit;
  logic [4:0]       low_code;

  always_comb begin
    low_code = 5'd0;
    for (int k = CODE_N - 1; k >= 1; k--)
      if (sync_req[k]) low_code = 5'(k);
  end

  assign sync_any     = |sync_req[CODE_N-1:1];
  assign irq_hit      = ie_q & ~el_q & |(pend_q & mask_q[7:PAD]);
  assign trap         = sync_any | irq_hit;
  assign trap_code    = sync_any ? low_code : 5'd0;
  assign resume_valid = eret;
  assign resume_pc    = epc_r;
  assign epc_q        = epc_r;
  assign status_q     = {16'b0, mask_q, 3'b0, um_q, 2'b0, el_q, ie_q};
  assign cause_q      = {bd_q, 15'b0, pend_q, {PAD{1'b0}}, 1'b0, code_q, 2'b0};

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = status_q;
      2'd1:    reg_rdata = cause_q;
      2'd2:    reg_rdata = epc_r;
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0; um_q <= 1'b0; el_q <= 1'b0; ie_q <= 1'b0;
      bd_q <= 1'b0; code_q <= '0; pend_q <= '0; epc_r <= '0;
    end else begin
      pend_q <= irq;
      if (trap) begin
        el_q   <= 1'b1;
        bd_q   <= in_delay;
        code_q <= trap_code;
        epc_r  <= in_delay ? fault_pc - 32'd4 : fault_pc;
      end else if (eret) begin
        el_q <= 1'b0;
      end else if (reg_we) begin
        if (reg_sel == 2'd0) begin
          mask_q <= reg_wdata[15:8];
          um_q   <= reg_wdata[4];
          el_q   <= reg_wdata[1];
          ie_q   <= reg_wdata[0];
        end else if (reg_sel == 2'd2) begin
          epc_r <= reg_wdata;
        end
      end
    end
  end

  a_r7_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> status_q[1]);
  a_r7_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> cause_q[6:2] == $past(trap_code));
  a_r7_delay_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> cause_q[31] == $past(in_delay));
  a_r8_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !trap) |=> !status_q[1]);
  a_r3_pending_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cause_q[15:8] == {$past(irq), {PAD{1'b0}}});
  a_r2_cause_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1 && !trap) |=> $stable(cause_q[31:16]) && $stable(cause_q[6:0]));
  a_r6_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req[1] && trap) |-> trap_code == 5'd1);
endmodule

// File: tb/exc_state_regs_tb.sv
module exc_state_regs_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] sync_req = '0;
  logic [5:0]  irq = '0;
  logic [31:0] fault_pc = '0, reg_wdata = '0;
  logic        in_delay = 1'b0, eret = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_rdata, resume_pc, status_q, cause_q, epc_q;
  logic        trap, resume_valid;
  logic [4:0]  trap_code;
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  exc_state_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .irq(irq),
    .fault_pc(fault_pc), .in_delay(in_delay), .eret(eret),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trap(trap), .trap_code(trap_code),
    .resume_valid(resume_valid), .resume_pc(resume_pc),
    .status_q(status_q), .cause_q(cause_q), .epc_q(epc_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset values
    chk("R1 reset status", status_q, 32'h0);
    chk("R1 reset cause", cause_q, 32'h0);
    chk("R1 reset epc", epc_q, 32'h0);
    chk("R1 reset trap", {31'b0, trap}, 32'h0);

    // R1 writable fields
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R1 status mask", status_q, 32'h0000_FF13);
    reg_sel = 2'd0; #1 chk("R1 read status", reg_rdata, 32'h0000_FF13);
    reg_sel = 2'd3; #1 chk("R1 read sel3", reg_rdata, 32'h0);

    // R4 blocked by level
    irq = 6'h3F; tick(); #1
    chk("R4 level blocks", {31'b0, trap}, 32'h0);
    chk("R3 pending all", cause_q, 32'h0000_FC00);
    wr(2'd0, 32'h0000_FF00); #1
    chk("R4 enable blocks", {31'b0, trap}, 32'h0);
    irq = 6'h0; tick();

    // R4 sweep all masks vs all lines
    for (int m = 0; m < 64; m++) begin
      for (int p = 0; p < 64; p++) begin
        wr(2'd0, {16'b0, 6'(m), 2'b0, 8'h01});
        irq = 6'(p);
        tick(); #1
        chk("R4 take", {31'b0, trap}, {31'b0, ((m & p) != 0)});
        if ((m & p) != 0) chk("R4 code0", {27'b0, trap_code}, 32'h0);
        chk("R3 pending", {16'b0, cause_q[15:0]} & 32'h0000_FF00, {16'b0, 6'(p), 10'b0});
        irq = 6'h0;
        tick(); tick();
      end
    end

    // R5 bit 0 ignored
    wr(2'd0, 32'h0);
    snap = cause_q;
    sync_req = 16'h0001; #1
    chk("R5 bit0 trap", {31'b0, trap}, 32'h0);
    tick(); sync_req = '0;
    chk("R5 bit0 cause", cause_q, snap);
    chk("R5 bit0 level", {31'b0, status_q[1]}, 32'h0);

    // R5/R6 pairs of codes
    for (int i = 1; i < 16; i++) begin
      for (int j = 1; j < 16; j++) begin
        sync_req = 16'(1 << i) | 16'(1 << j); #1
        chk("R5 trap", {31'b0, trap}, 32'h1);
        chk("R6 lowest", {27'b0, trap_code}, (i < j) ? i : j);
        tick(); sync_req = '0;
        chk("R7 code kept", {27'b0, cause_q[6:2]}, (i < j) ? i : j);
      end
    end

    // R6 sync beats interrupt
    wr(2'd0, 32'h0000_FF01);
    irq = 6'h01; tick();
    sync_req = 16'h2000; #1
    chk("R6 sync over irq", {27'b0, trap_code}, 32'd13);
    tick(); sync_req = '0; irq = '0; tick();

    // R7 delay slot
    wr(2'd0, 32'h0);
    fault_pc = 32'h0000_1000; in_delay = 1'b1; sync_req = 16'h0100; #1
    chk("R5 code 8", {27'b0, trap_code}, 32'd8);
    tick(); sync_req = '0;
    chk("R7 epc delay", epc_q, 32'h0000_0FFC);
    chk("R7 bd set", {31'b0, cause_q[31]}, 32'h1);
    chk("R7 level", {31'b0, status_q[1]}, 32'h1);
    fault_pc = 32'h0000_2000; in_delay = 1'b0; sync_req = 16'h1000;
    tick(); sync_req = '0;
    chk("R7 epc plain", epc_q, 32'h0000_2000);
    chk("R7 bd clear", {31'b0, cause_q[31]}, 32'h0);

    // R8 return
    eret = 1'b1; #1
    chk("R8 resume valid", {31'b0, resume_valid}, 32'h1);
    chk("R8 resume pc", resume_pc, 32'h0000_2000);
    tick(); eret = 1'b0;
    chk("R8 level cleared", {31'b0, status_q[1]}, 32'h0);

    // R9 trap over return and write
    sync_req = 16'h0010; eret = 1'b1; fault_pc = 32'h0000_3000;
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'hDEAD_BEEF;
    tick(); sync_req = '0; eret = 1'b0; reg_we = 1'b0;
    chk("R9 trap wins level", {31'b0, status_q[1]}, 32'h1);
    chk("R9 trap wins epc", epc_q, 32'h0000_3000);
    chk("R9 trap code", {27'b0, cause_q[6:2]}, 32'd4);
    // R9 return over write
    eret = 1'b1; reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_0002;
    tick(); eret = 1'b0; reg_we = 1'b0;
    chk("R9 return wins", {31'b0, status_q[1]}, 32'h0);

    // R2 cause read-only
    snap = cause_q;
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R2 cause unchanged", cause_q, snap);
    // R9 EPC write
    wr(2'd2, 32'h1234_5678);
    reg_sel = 2'd2; #1 chk("R9 epc write", reg_rdata, 32'h1234_5678);
    reg_sel = 2'd1; #1 chk("R1 read cause", reg_rdata, cause_q);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule